// File: doc/BRIEF.md
# Programmable Frame Sync Generator

This block produces the bit clock and the frame-sync pulse for a serial audio link. The bit clock either comes from a fixed divide of the system clock or from an external bit-clock pin. A frame counter runs on that bit clock and drives a frame-sync level whose length and active part are set by two fields: one for the period and one for the width. A one-cycle frame-start strobe marks every frame.

Two separate enables bring the block out of reset. The first starts the clock generator. The second allows the frame-sync output to be driven. Two drive bits choose the pin directions. When the bit clock is driven, the internal divider is the source. When only frame sync is driven, the external bit clock feeds the counter. When neither is driven, the generator stays idle. Two polarity bits set the sense of the bit clock and of the frame sync. In continuous mode a new frame starts after every period. When continuous mode is off, a frame starts only after a request.

Top module: `frame_sync_gen`

## Requirements
- R1: In a running frame, consecutive frame-start strobes are `period`+1 bit-clock rising edges apart.
- R2: Frame sync is at its active level for `width`+1 bit clocks, starting at the frame start. If `width` >= `period`, it stays active for the whole frame.
- R3: A new `period`, `width` value written in the middle of a frame does not change the current frame. It takes effect from the next frame start.
- R4: With `cont_mode`=1, frames repeat without a break. With `cont_mode`=0, the running frame ends and no further frame starts until a `frame_req` pulse arrives. Each pulse starts exactly one frame.
- R5: While `gen_en`=0, `bclk_o` rests at the level of `bclk_inv` and no frame starts. When the generator runs from the internal source, `bclk_o` has a period of 2*DIV_HALF system clocks.
- R6: While `fs_en`=0, the bit clock still runs, but `fsync_o` stays at its inactive level and `frame_start` stays low. Setting `fs_en` starts frames.
- R7: With `clk_drive`=0 and `fs_drive`=1, `bclk_oe` is 0 and the frame counter advances on rising edges of `ext_bclk`. One frame lasts (`period`+1) external bit-clock periods.
- R8: With `clk_drive`=0 and `fs_drive`=0, no frame starts and `bclk_o` does not toggle, even with `gen_en`=1.
- R9: `fs_inv`=1 makes the frame-sync active level low. `bclk_inv`=1 inverts `bclk_o`.
- R10: `frame_start` is high for exactly one system cycle. It is high in the cycle where frame sync goes active and, in internal mode, where `bclk_o` rises.
- R11: After reset, `bclk_o`=`bclk_inv`, `fsync_o`=`fs_inv` and `frame_start`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gen_en | input | 1 | Releases the clock generator |
| fs_en | input | 1 | Releases the frame-sync output |
| clk_drive | input | 1 | 1: internal bit clock drives the pin; 0: external bit clock is the source |
| fs_drive | input | 1 | 1: frame sync is driven by this block |
| cont_mode | input | 1 | 1: frames repeat every period; 0: frames start on request |
| frame_req | input | 1 | Requests one frame when cont_mode is 0 |
| period | input | PER_W | Bit clocks per frame minus one |
| width | input | PER_W | Active sync bit clocks minus one |
| bclk_inv | input | 1 | Inverts the bit clock output |
| fs_inv | input | 1 | 1: frame sync active low |
| ext_bclk | input | 1 | External bit clock (asynchronous) |
| bclk_o | output | 1 | Bit clock output |
| bclk_oe | output | 1 | Bit clock pin output enable |
| fsync_o | output | 1 | Frame sync output |
| fsync_oe | output | 1 | Frame sync pin output enable |
| frame_start | output | 1 | One-cycle strobe at each frame start |

## Verification
The bench measures whole frames in bit-clock edges for several combinations of period, width and polarity. It includes a width larger than the period: a design that compares with the wrong bound would release the sync inside the frame. The period is rewritten in the middle of a frame. A design without shadow registers would shorten that frame instead of the next one.

On-request mode is checked for a clean stop and for exactly one frame per request. A design that does not consume the request would keep running. The two enables and the idle drive setting are held for long windows so that any stray strobe or toggle is seen. External-clock mode is timed against a known external period, which exposes a missed or doubled edge detect.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic {
        SRC_EXT = 1'b0,
        SRC_INT = 1'b1
    } clk_src_e;

    function automatic clk_src_e pick_source(input logic drive_bclk);
        return drive_bclk ? SRC_INT : SRC_EXT;
    endfunction

endpackage

// File: rtl/fsg_bitclk.sv
module fsg_bitclk
    import fsg_pkg::*;
#(
    parameter int DIV_HALF = 2,
    localparam int DCW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  clk_src_e src,
    input  logic     ext_bclk,
    output logic     tick,
    output logic     bclk_lvl
);

    typedef struct packed {
        logic [DCW-1:0] div;
        logic           lvl;
        logic [2:0]     sync;
    } bc_state_t;

    bc_state_t st_q, st_d;
    logic      int_tick;
    logic      ext_rise;
    logic      wrap;

    always_comb begin
        st_d     = st_q;
        int_tick = 1'b0;
        st_d.sync = {st_q.sync[1:0], ext_bclk};
        wrap     = (st_q.div == DCW'(DIV_HALF - 1));
        if (run && src == SRC_INT) begin
            if (wrap) begin
                st_d.div = '0;
                st_d.lvl = ~st_q.lvl;
                int_tick = ~st_q.lvl;
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
        end else begin
            st_d.div = '0;
            st_d.lvl = 1'b0;
        end
        ext_rise = st_q.sync[1] & ~st_q.sync[2];
        tick     = run && ((src == SRC_INT) ? int_tick : ext_rise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bclk_lvl = st_q.lvl;

endmodule

// File: rtl/fsg_framer.sv
module fsg_framer #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             fs_en,
    input  logic             cont_mode,
    input  logic             frame_req,
    input  logic [PER_W-1:0] period,
    input  logic [PER_W-1:0] width,
    output logic             fs_act,
    output logic             strobe
);

    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic [PER_W-1:0] per;
        logic [PER_W-1:0] wid;
        logic             started;
        logic             pend;
        logic             act;
        logic             stb;
    } fr_state_t;

    fr_state_t st_q, st_d;
    logic      begin_frame;
    logic      may_start;

    always_comb begin
        st_d        = st_q;
        st_d.stb    = 1'b0;
        begin_frame = 1'b0;
        may_start   = cont_mode || st_q.pend;
        if (!run) begin
            st_d.started = 1'b0;
            st_d.cnt     = '0;
            st_d.act     = 1'b0;
        end else if (tick) begin
            if (!st_q.started || st_q.cnt == st_q.per) begin
                if (may_start) begin
                    begin_frame  = 1'b1;
                    st_d.started = 1'b1;
                    st_d.cnt     = '0;
                    st_d.per     = period;
                    st_d.wid     = width;
                    st_d.pend    = 1'b0;
                end else begin
                    st_d.started = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            st_d.act = st_d.started && (st_d.cnt <= st_d.wid);
            st_d.stb = begin_frame && fs_en;
        end
        if (frame_req) st_d.pend = 1'b1;
        if (!fs_en)    st_d.act  = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fs_act = st_q.act;
    assign strobe = st_q.stb;

endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen
    import fsg_pkg::*;
#(
    parameter int PER_W    = 8,
    parameter int DIV_HALF = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic             fs_en,
    input  logic             clk_drive,
    input  logic             fs_drive,
    input  logic             cont_mode,
    input  logic             frame_req,
    input  logic [PER_W-1:0] period,
    input  logic [PER_W-1:0] width,
    input  logic             bclk_inv,
    input  logic             fs_inv,
    input  logic             ext_bclk,
    output logic             bclk_o,
    output logic             bclk_oe,
    output logic             fsync_o,
    output logic             fsync_oe,
    output logic             frame_start
);

    logic     run;
    logic     tick;
    logic     bclk_lvl;
    logic     fs_act;
    clk_src_e src;

    assign run = gen_en && (clk_drive || fs_drive);
    assign src = pick_source(clk_drive);

    fsg_bitclk #(.DIV_HALF(DIV_HALF)) u_bitclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .src      (src),
        .ext_bclk (ext_bclk),
        .tick     (tick),
        .bclk_lvl (bclk_lvl)
    );

    fsg_framer #(.PER_W(PER_W)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .tick      (tick),
        .fs_en     (fs_en),
        .cont_mode (cont_mode),
        .frame_req (frame_req),
        .period    (period),
        .width     (width),
        .fs_act    (fs_act),
        .strobe    (frame_start)
    );

    assign bclk_o   = bclk_lvl ^ bclk_inv;
    assign bclk_oe  = clk_drive;
    assign fsync_o  = fs_act ^ fs_inv;
    assign fsync_oe = fs_drive;

endmodule

// File: rtl/frame_sync_gen_chk.sv
module frame_sync_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic gen_en,
    input logic fs_en,
    input logic clk_drive,
    input logic fs_drive,
    input logic bclk_inv,
    input logic fs_inv,
    input logic bclk_o,
    input logic fsync_o,
    input logic frame_start
);

    // R10
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R10
    strobe_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (fsync_o != fs_inv));

    // R6
    strobe_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_en |-> !frame_start);

    // R6
    fs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fs_en && !$past(fs_en)) |-> (fsync_o == fs_inv));

    // R5
    gen_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_en && !$past(gen_en)) |-> (bclk_o == bclk_inv && !frame_start));

    // R8
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_drive && !fs_drive) |=> !frame_start);

endmodule

bind frame_sync_gen frame_sync_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gen_en      (gen_en),
    .fs_en       (fs_en),
    .clk_drive   (clk_drive),
    .fs_drive    (fs_drive),
    .bclk_inv    (bclk_inv),
    .fs_inv      (fs_inv),
    .bclk_o      (bclk_o),
    .fsync_o     (fsync_o),
    .frame_start (frame_start)
);

// File: tb/sim_frame_sync_gen.sv
`timescale 1ns/1ps
module sim_frame_sync_gen;

    localparam int PW = 8;
    localparam int NV = 5;
    // {fs_inv, period, width}
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 8'd31, 8'd15},
        {1'b0, 8'd7,  8'd0},
        {1'b1, 8'd15, 8'd3},
        {1'b0, 8'd5,  8'd9},
        {1'b1, 8'd2,  8'd1}
    };

    logic          clk = 0;
    logic          rst_n = 0;
    logic          gen_en = 0, fs_en = 0, clk_drive = 1, fs_drive = 1;
    logic          cont_mode = 1, frame_req = 0;
    logic [PW-1:0] period = 8'd31, width = 8'd15;
    logic          bclk_inv = 0, fs_inv = 0, ext_bclk = 0, ext_run = 0;
    logic          bclk_o, bclk_oe, fsync_o, fsync_oe, frame_start;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    frame_sync_gen #(.PER_W(PW), .DIV_HALF(2)) u0 (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .fs_en(fs_en),
        .clk_drive(clk_drive), .fs_drive(fs_drive), .cont_mode(cont_mode),
        .frame_req(frame_req), .period(period), .width(width),
        .bclk_inv(bclk_inv), .fs_inv(fs_inv), .ext_bclk(ext_bclk),
        .bclk_o(bclk_o), .bclk_oe(bclk_oe), .fsync_o(fsync_o),
        .fsync_oe(fsync_oe), .frame_start(frame_start)
    );

    always #10 clk = ~clk;

    initial begin
        #5;
        forever begin
            #50;
            if (ext_run) ext_bclk = ~ext_bclk;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Measures one frame: units are bit-clock rises, or system cycles when by_cycle.
    task automatic measure(input bit by_cycle, input int chg_at, input int new_per,
                           output int units, output int act);
        logic prev;
        bit   edge_seen;
        int   guard;
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!frame_start && guard < 5000);
        units = 1;
        act   = (fsync_o != fs_inv) ? 1 : 0;
        prev  = bclk_o ^ bclk_inv;
        while (guard < 10000) begin
            @(negedge clk);
            guard++;
            edge_seen = by_cycle ? 1'b1 : ((bclk_o ^ bclk_inv) && !prev);
            prev = bclk_o ^ bclk_inv;
            if (edge_seen) begin
                if (frame_start) break;
                units++;
                if (fsync_o != fs_inv) act++;
                if (units == chg_at) period = PW'(new_per);
            end
        end
        if (guard >= 10000) units = -1;
    endtask

    task automatic window(input int n, output int strobes, output int rises, output int fs_on);
        logic prev;
        strobes = 0; rises = 0; fs_on = 0;
        prev = bclk_o;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (frame_start) strobes++;
            if (bclk_o && !prev) rises++;
            if (fsync_o != fs_inv) fs_on++;
            prev = bclk_o;
        end
    endtask

    initial begin
        int u, a, s, r, f, p, w, exp_a;
        repeat (4) @(negedge clk);
        // R11: reset state
        chk("R11 bclk_o", int'(bclk_o), 0);
        chk("R11 fsync_o", int'(fsync_o), 0);
        chk("R11 frame_start", int'(frame_start), 0);
        rst_n = 1;
        @(negedge clk);
        gen_en = 1; fs_en = 1;

        // R1 R2 R9 R10: table walk
        for (int k = 0; k < NV; k++) begin
            fs_inv = VEC[k][16];
            p = int'(VEC[k][15:8]);
            w = int'(VEC[k][7:0]);
            period = VEC[k][15:8];
            width  = VEC[k][7:0];
            measure(0, -1, 0, u, a);   // frame may straddle the change
            measure(0, -1, 0, u, a);
            exp_a = (w < p) ? w + 1 : p + 1;
            chk("R1 frame length", u, p + 1);
            chk(fs_inv ? "R9 R2 active-low width" : "R2 active width", a, exp_a);
        end

        // R3: mid-frame period change applies at next frame
        fs_inv = 0; period = 8'd31; width = 8'd15;
        measure(0, -1, 0, u, a);
        measure(0, -1, 0, u, a);
        measure(0, 3, 7, u, a);
        chk("R3 current frame kept", u, 32);
        measure(0, -1, 0, u, a);
        chk("R3 new period next frame", u, 8);

        // R9: bit clock inversion
        bclk_inv = 1;
        measure(0, -1, 0, u, a);
        measure(0, -1, 0, u, a);
        chk("R9 inverted bclk frame length", u, 8);
        bclk_inv = 0;

        // R4: on-request mode
        period = 8'd31;
        repeat (300) @(negedge clk);
        cont_mode = 0;
        repeat (300) @(negedge clk);
        window(600, s, r, f);
        chk("R4 stop without request", s, 0);
        frame_req = 1; @(negedge clk); frame_req = 0;
        window(600, s, r, f);
        chk("R4 one frame per request", s, 1);
        cont_mode = 1;

        // R6: frame sync held off
        fs_en = 0;
        window(300, s, r, f);
        chk("R6 no strobe", s, 0);
        chk("R6 sync inactive", f, 0);
        chk("R6 bclk runs", int'(r >= 70), 1);
        fs_en = 1;
        measure(0, -1, 0, u, a);
        chk("R6 frames after release", u, 32);

        // R5: generator held off
        gen_en = 0; bclk_inv = 1;
        window(200, s, r, f);
        chk("R5 no strobe", s, 0);
        chk("R5 bclk at rest", int'(bclk_o), 1);
        chk("R5 no bclk edges", r, 0);
        bclk_inv = 0; gen_en = 1;
        window(400, s, r, f);
        chk("R5 bclk rate", r, 100);

        // R8: idle when neither pin is driven
        clk_drive = 0; fs_drive = 0;
        window(300, s, r, f);
        chk("R8 no strobe", s, 0);
        chk("R8 no bclk edges", r, 0);

        // R7: external bit clock
        fs_drive = 1; ext_run = 1; period = 8'd7; width = 8'd2;
        chk("R7 bclk_oe low", int'(bclk_oe), 0);
        measure(1, -1, 0, u, a);
        measure(1, -1, 0, u, a);
        chk("R7 frame cycles", u, 8 * 5);
        chk("R7 active cycles", a, 3 * 5);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule